// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block drives an SDRAM device through its required start-up sequence once reset is released. First it waits a stabilization interval. Then it issues one precharge of all banks, waits the precharge recovery time, and issues a programmable number of auto-refresh commands. Each refresh is followed by its own recovery gap. Finally it loads the mode register with a value supplied on an input port and raises a completion flag once the mode-load delay has elapsed.

Clock enable and every data-mask bit are held high at all times, so the device keeps its data pins in high impedance and no bus contention can occur. Every wait is a parameter given in clock cycles. The integrator derives these values from the clock frequency, for example 10000 cycles for 200 µs at 50 MHz.

Command encoding on `cmd_o` is {RAS#, CAS#, WE#} with chip select taken as active:

| Command | Code |
|---|---|
| NOP | 3'b111 |
| precharge-all | 3'b010 |
| auto-refresh | 3'b001 |
| mode-register load | 3'b000 |

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `cmd_o` is NOP (3'b111), `addr_o` is all zeros and `init_done_o` is low; reset asserted in the middle of a sequence restarts the whole sequence.
- R2: `cke_o` and every bit of `dqm_o` are high in every cycle, including during reset.
- R3: Precharge-all (3'b010) appears on `cmd_o` in the cycle after the WAIT_CYC-th rising edge following reset release, with `addr_o` bit AP_BIT set and all other address bits zero.
- R4: The first auto-refresh (3'b001) appears exactly TRP_CYC cycles after the precharge-all, with `addr_o` all zeros.
- R5: Exactly REF_COUNT auto-refresh commands are issued, consecutive ones spaced TRP-independent TRFC_CYC cycles apart.
- R6: The mode-register load (3'b000) appears TRFC_CYC cycles after the last auto-refresh, with `addr_o` equal to `mode_value_i` in that cycle.
- R7: `init_done_o` rises exactly TMRD_CYC cycles after the mode-register load and then stays high, and only NOP is driven from then until the next reset.
- R8: Every non-NOP command lasts exactly one cycle, and NOP is driven in every cycle that carries none of the timed commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, already stable |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_value_i | input | ADDR_W | Value placed on the address bus for the mode-register load |
| cmd_o | output | 3 | Command as {RAS#, CAS#, WE#} |
| addr_o | output | ADDR_W | Device address bus |
| cke_o | output | 1 | Clock enable, held high |
| dqm_o | output | DQM_W | Data-mask lines, held high |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
A wrong internal state shows up at the ports as a command in the wrong cycle. An off-by-one in the timer shifts every later command by one cycle, and this is visible at the precharge-all itself. A refresh counter that miscounts changes the number of refreshes, or moves the mode load, within one refresh gap of the point of error. A state that fails to settle after completion appears as a stray command, or as `init_done_o` dropping in the next cycle. The scoreboard holds the cycle, code and address of each expected command and compares every non-NOP cycle against it, so any such deviation is reported at the cycle where it occurs.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      CMD_MRS  = 3'b000,
      CMD_REF  = 3'b001,
      CMD_PALL = 3'b010,
      CMD_NOP  = 3'b111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_PALL,
      ST_TRP,
      ST_REF,
      ST_TRFC,
      ST_MRS,
      ST_TMRD,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int CNT_W   = 14,
   parameter int RST_VAL = 9999
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         count_q <= CNT_W'(RST_VAL);
      else if (load_i)
         count_q <= load_val_i;
      else if (count_q != '0)
         count_q <= count_q - 1'b1;
   end

   assign zero_o = (count_q == '0);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
   parameter int REF_COUNT = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inc_i,
   output logic all_issued_o
);

   localparam int RC_W = $clog2(REF_COUNT + 1);

   logic [RC_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign all_issued_o = (cnt_q == RC_W'(REF_COUNT));

   // R5: no refresh beyond the programmed count
   assert_ref_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      all_issued_o |-> !inc_i);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DQM_W     = 2,
   parameter int AP_BIT    = 10,
   parameter int WAIT_CYC  = 10000,
   parameter int TRP_CYC   = 3,
   parameter int TRFC_CYC  = 7,
   parameter int TMRD_CYC  = 2,
   parameter int REF_COUNT = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] mode_value_i,
   output logic [2:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cke_o,
   output logic [DQM_W-1:0]  dqm_o,
   output logic              init_done_o
);

   localparam int MAX_GAP  = (TRFC_CYC > TRP_CYC) ?
                             ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC) :
                             ((TRP_CYC  > TMRD_CYC) ? TRP_CYC  : TMRD_CYC);
   localparam int MAX_CYC  = (WAIT_CYC > MAX_GAP) ? WAIT_CYC : MAX_GAP;
   localparam int TW       = $clog2(MAX_CYC + 1);

   generate
      if (REF_COUNT < 8) begin : g_chk_refs
         $error("REF_COUNT must be at least 8");
      end
      if (TRP_CYC < 2 || TRFC_CYC < 2 || TMRD_CYC < 2) begin : g_chk_gaps
         $error("TRP_CYC, TRFC_CYC and TMRD_CYC must each be at least 2");
      end
      if (WAIT_CYC < 1) begin : g_chk_wait
         $error("WAIT_CYC must be at least 1");
      end
      if (AP_BIT >= ADDR_W) begin : g_chk_ap
         $error("AP_BIT must lie inside the address bus");
      end
   endgenerate

   seq_state_e    state_q, state_d;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_zero;
   logic          ref_inc;
   logic          refs_all;

   sdram_init_timer #(
      .CNT_W   (TW),
      .RST_VAL (WAIT_CYC - 1)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   sdram_init_refcnt #(
      .REF_COUNT (REF_COUNT)
   ) u_refcnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .inc_i        (ref_inc),
      .all_issued_o (refs_all)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         state_q <= ST_WAIT;
      else
         state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      ref_inc  = 1'b0;
      unique case (state_q)
         ST_WAIT: if (tmr_zero) state_d = ST_PALL;
         ST_PALL: begin
            tmr_load = 1'b1;
            tmr_val  = TW'(TRP_CYC - 2);
            state_d  = ST_TRP;
         end
         ST_TRP:  if (tmr_zero) state_d = ST_REF;
         ST_REF: begin
            tmr_load = 1'b1;
            tmr_val  = TW'(TRFC_CYC - 2);
            ref_inc  = 1'b1;
            state_d  = ST_TRFC;
         end
         ST_TRFC: if (tmr_zero) state_d = refs_all ? ST_MRS : ST_REF;
         ST_MRS: begin
            tmr_load = 1'b1;
            tmr_val  = TW'(TMRD_CYC - 2);
            state_d  = ST_TMRD;
         end
         ST_TMRD: if (tmr_zero) state_d = ST_DONE;
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_WAIT;
      endcase
   end

   always_comb begin
      cmd_o  = CMD_NOP;
      addr_o = '0;
      unique case (state_q)
         ST_PALL: begin
            cmd_o          = CMD_PALL;
            addr_o[AP_BIT] = 1'b1;
         end
         ST_REF:  cmd_o = CMD_REF;
         ST_MRS: begin
            cmd_o  = CMD_MRS;
            addr_o = mode_value_i;
         end
         default: cmd_o = CMD_NOP;
      endcase
   end

   assign cke_o       = 1'b1;
   assign dqm_o       = '1;
   assign init_done_o = (state_q == ST_DONE);

   // R8: a timed command never occupies two cycles in a row
   assert_single_cycle_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));

   // R6: the mode load waits for the full refresh count
   assert_mrs_after_refs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_MRS) |-> refs_all);

   // R7: completion is sticky
   assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_done_o |=> init_done_o);

   // R7: nothing but NOP once complete
   assert_quiet_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_done_o |-> (cmd_o == CMD_NOP));

   // R4: a refresh is always preceded by a NOP gap
   assert_gap_before_ref_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == CMD_REF) |-> $past(cmd_o) == CMD_NOP);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

   localparam int ADDR_W    = 13;
   localparam int DQM_W     = 2;
   localparam int AP_BIT    = 10;
   localparam int WAIT_CYC  = 10000;
   localparam int TRP_CYC   = 3;
   localparam int TRFC_CYC  = 7;
   localparam int TMRD_CYC  = 2;
   localparam int REF_COUNT = 8;

   localparam logic [2:0] C_NOP  = 3'b111;
   localparam logic [2:0] C_PALL = 3'b010;
   localparam logic [2:0] C_REF  = 3'b001;
   localparam logic [2:0] C_MRS  = 3'b000;

   typedef struct {
      int               cyc;
      logic [2:0]       cmd;
      logic [ADDR_W-1:0] addr;
      string            req;
   } exp_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] mode_val = '0;
   logic [2:0]        cmd;
   logic [ADDR_W-1:0] addr;
   logic              cke;
   logic [DQM_W-1:0]  dqm;
   logic              done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int done_cyc = 0;
   bit running = 1'b0;
   exp_item_t exp_q[$];

   always #10 clk = ~clk;

   sdram_init_seq #(
      .ADDR_W (ADDR_W), .DQM_W (DQM_W), .AP_BIT (AP_BIT),
      .WAIT_CYC (WAIT_CYC), .TRP_CYC (TRP_CYC), .TRFC_CYC (TRFC_CYC),
      .TMRD_CYC (TMRD_CYC), .REF_COUNT (REF_COUNT)
   ) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .mode_value_i (mode_val),
      .cmd_o (cmd), .addr_o (addr), .cke_o (cke), .dqm_o (dqm),
      .init_done_o (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, expv);
      end
   endtask

   task automatic push_expected(input logic [ADDR_W-1:0] mv);
      exp_item_t it;
      logic [ADDR_W-1:0] pa;
      int t;
      exp_q.delete();
      pa = '0;
      pa[AP_BIT] = 1'b1;
      t = WAIT_CYC;
      it = '{cyc: t, cmd: C_PALL, addr: pa, req: "R3"};
      exp_q.push_back(it);
      t += TRP_CYC;
      for (int i = 0; i < REF_COUNT; i++) begin
         it = '{cyc: t, cmd: C_REF, addr: '0, req: (i == 0) ? "R4" : "R5"};
         exp_q.push_back(it);
         t += TRFC_CYC;
      end
      it = '{cyc: t, cmd: C_MRS, addr: mv, req: "R6"};
      exp_q.push_back(it);
      done_cyc = t + TMRD_CYC;
   endtask

   // monitor: samples on the falling edge, cyc = rising edges since release
   always @(negedge clk) begin
      if (running) begin
         check(cke === 1'b1 && dqm === '1, "R2", {cke, dqm}, {1'b1, {DQM_W{1'b1}}});
         if (cmd !== C_NOP) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", cmd, C_NOP);
            end else begin
               exp_item_t it;
               it = exp_q.pop_front();
               check(it.cyc == cyc, it.req, cyc, it.cyc);
               check(cmd === it.cmd, it.req, cmd, it.cmd);
               check(addr === it.addr, it.req, addr, it.addr);
            end
         end else if (exp_q.size() != 0 && exp_q[0].cyc == cyc) begin
            check(1'b0, exp_q[0].req, cmd, exp_q[0].cmd);
            void'(exp_q.pop_front());
         end
         if (cyc == done_cyc - 1 || cyc == done_cyc || cyc == done_cyc + 15)
            check(done === (cyc >= done_cyc), "R7", done, cyc >= done_cyc);
         cyc++;
      end
   end

   task automatic apply_reset();
      @(negedge clk);
      running = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(cmd === C_NOP, "R1", cmd, C_NOP);
      check(addr === '0, "R1", addr, 0);
      check(done === 1'b0, "R1", done, 0);
      check(cke === 1'b1 && dqm === '1, "R2", {cke, dqm}, {1'b1, {DQM_W{1'b1}}});
   endtask

   task automatic run_seq(input logic [ADDR_W-1:0] mv, input int stop_after);
      apply_reset();
      mode_val = mv;
      push_expected(mv);
      cyc = 0;
      rst_n = 1'b1;
      running = 1'b1;
      wait (cyc >= stop_after);
   endtask

   initial begin
      // partial run, then reset in the middle of the refresh phase (R1)
      run_seq(13'h0033, WAIT_CYC + TRP_CYC + 2 * TRFC_CYC + 1);
      // full runs with two distinct mode values
      run_seq(13'h0232, WAIT_CYC + TRP_CYC + REF_COUNT * TRFC_CYC + TMRD_CYC + 20);
      check(exp_q.size() == 0, "R5", exp_q.size(), 0);
      mode_val = 13'h1FFF; // changing the input after completion must not emit a command (R7)
      repeat (5) @(negedge clk);
      run_seq(13'h1C27, WAIT_CYC + TRP_CYC + REF_COUNT * TRFC_CYC + TMRD_CYC + 20);
      check(exp_q.size() == 0, "R5", exp_q.size(), 0);
      running = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule